// File: doc/BRIEF.md
# Cascadable Bit-Serial Configuration Memory

This block models a read-only configuration memory that streams its contents one bit at a time toward a loader that generates the shift clock. The stored bits are fixed by a parameter at elaboration. An internal address pointer picks the bit currently presented. The pointer moves forward by one on each rising clock edge at which the device is driving data. Several devices can be chained. Each device's cascade-enable output feeds the active-low chip enable of the next one. The whole chain then behaves as one long serial memory on a shared data line.

The outgoing bit stream is a valid/ready stream without a ready wire. `data_en` is the valid flag and `data_o` is the bit. The loader consumes a bit at every rising edge of `clk` while `data_en` is high. Back-pressure has two forms. Holding `ce_n` high stalls the device: the line is released and the pointer freezes, so the next read resumes exactly where it stopped. Driving the combined reset/output-enable pin to its reset level also releases the line, and it rewinds the pointer. The polarity of that pin is a parameter. When the last configured address has been consumed, the device releases its data line and pulls `ceo_n` low. The downstream device then drives the shared line in that same cycle. Keeping the pointer through stalls lets several programs be stored back to back and read one after another.

Top module: `serial_cfg_prom`

## Requirements
- R1: While `data_en` is high, `data_o` equals bit `p` of the `CONTENT` parameter, where `p` is the pointer. Bit index 0 (the LSB) is address 0. Each rising edge with `data_en` high advances the pointer by one.
- R2: While `ce_n` is high, `data_en` is low and the pointer holds its value. Enabling again resumes at the next unread address, so programs stored back to back are read in sequence.
- R3: While the reset/output-enable pin is at its reset level, `data_en` is low. The next rising edge returns the pointer to address 0.
- R4: With `POLARITY` = `RST_HIGH_OE_LOW` (0), a high pin is reset and a low pin is output-enable. With `RST_LOW_OE_HIGH` (1), the levels are swapped.
- R5: A high `por` at a rising edge returns the pointer to address 0. While `por` is high, `data_en` is low and `data_o` is 0.
- R6: `ceo_n` is low exactly when address `LAST_ADDR` has been consumed (and no reset has occurred since) and `ce_n` is low. `data_en` is never high while `ceo_n` is low.
- R7: In a chain, the downstream device presents its first bit in the cycle right after the upstream device's last bit. The shared line never has a gap or two drivers. The received stream equals the upstream contents up to its `LAST_ADDR`, followed by the downstream contents.
- R8: Addresses above `LAST_ADDR` are never presented. Once spent, a device keeps its line released under further clocks until a reset.
- R9: When `data_en` is low, `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock from the loader; one bit per rising edge |
| por | input | 1 | Synchronous power-on reset, active high |
| rst_oe | input | 1 | Combined reset / output-enable pin, polarity per `POLARITY` |
| ce_n | input | 1 | Chip enable, active low |
| data_o | output | 1 | Serial data bit (valid when `data_en` is high) |
| data_en | output | 1 | Data line driven (low means high-impedance) |
| ceo_n | output | 1 | Cascade enable to the next device, active low |

## Verification
`data_en`, `data_o` and `ceo_n` are combinational in the pointer and the pins, so they reflect a pin change in the same cycle. A pointer move first shows up in the cycle after the consuming rising edge. A reset level or `por` present at an edge shows address 0 from the following cycle. The bench changes inputs 1 ns after the rising edge and advances its queue-based reference at the rising edge. It compares every output on the falling edge, half a period after the last register update. Two chained instances use opposite pin polarities behind one shared reset request. The stall, rewind and handoff results are therefore checked in the exact cycle each is due.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic {
    RST_HIGH_OE_LOW = 1'b0,
    RST_LOW_OE_HIGH = 1'b1
  } rstoe_pol_e;
endpackage

// File: rtl/scp_pin_decode.sv
module scp_pin_decode
  import scp_pkg::*;
#(
  parameter rstoe_pol_e POLARITY = RST_HIGH_OE_LOW
) (
  input  logic rst_oe,
  output logic rst_lvl
);
  generate
    if (POLARITY == RST_HIGH_OE_LOW) begin : g_high_rst
      assign rst_lvl = rst_oe;
    end else begin : g_low_rst
      assign rst_lvl = ~rst_oe;
    end
  endgenerate
endmodule

// File: rtl/scp_addr_ctr.sv
module scp_addr_ctr #(
  parameter int LAST_ADDR = 63,
  parameter int PW        = 7
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic          spent
);
  localparam logic [PW-1:0] END_PTR = PW'(LAST_ADDR + 1);

  assign spent = (ptr == END_PTR);

  always_ff @(posedge clk) begin
    if (clr) begin
      ptr <= '0;
    end else if (adv && !spent) begin
      ptr <= ptr + PW'(1);
    end
  end
endmodule

// File: rtl/scp_bit_store.sv
module scp_bit_store #(
  parameter int             DEPTH   = 64,
  parameter int             PW      = 7,
  parameter logic [DEPTH-1:0] CONTENT = '0
) (
  input  logic [PW-1:0] ptr,
  output logic          bit_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  always_comb begin
    if (int'(ptr) < DEPTH) bit_o = CONTENT[ptr[AW-1:0]];
    else                   bit_o = 1'b0;
  end
endmodule

// File: rtl/serial_cfg_prom.sv
module serial_cfg_prom
  import scp_pkg::*;
#(
  parameter int               DEPTH     = 64,
  parameter int               LAST_ADDR = DEPTH - 1,
  parameter logic [DEPTH-1:0] CONTENT   = 64'hF0E1_D2C3_B4A5_9687,
  parameter rstoe_pol_e       POLARITY  = RST_HIGH_OE_LOW
) (
  input  logic clk,
  input  logic por,
  input  logic rst_oe,
  input  logic ce_n,
  output logic data_o,
  output logic data_en,
  output logic ceo_n
);
  localparam int PW = $clog2(LAST_ADDR + 2);

  logic          rst_lvl;
  logic [PW-1:0] ptr;
  logic          spent;
  logic          cur_bit;
  logic          fire;

  scp_pin_decode #(.POLARITY(POLARITY)) u_pin (
    .rst_oe (rst_oe),
    .rst_lvl(rst_lvl)
  );

  scp_addr_ctr #(.LAST_ADDR(LAST_ADDR), .PW(PW)) u_ctr (
    .clk  (clk),
    .clr  (por | rst_lvl),
    .adv  (fire),
    .ptr  (ptr),
    .spent(spent)
  );

  scp_bit_store #(.DEPTH(DEPTH), .PW(PW), .CONTENT(CONTENT)) u_store (
    .ptr  (ptr),
    .bit_o(cur_bit)
  );

  assign fire    = ~por & ~rst_lvl & ~ce_n & ~spent;
  assign data_en = fire;
  assign data_o  = fire & cur_bit;
  assign ceo_n   = ~(spent & ~ce_n);
endmodule

// File: rtl/serial_cfg_prom_chk.sv
module serial_cfg_prom_chk #(
  parameter int LAST_ADDR = 63,
  parameter int PW        = 7
) (
  input logic          clk,
  input logic          por,
  input logic          rst_lvl,
  input logic          ce_n,
  input logic          data_o,
  input logic          data_en,
  input logic          ceo_n,
  input logic [PW-1:0] ptr,
  input logic          spent
);
  // R1
  adv_step_chk: assert property (@(posedge clk) disable iff (por)
    data_en |=> (ptr == $past(ptr) + PW'(1)));

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (por)
    (ce_n && !rst_lvl) |=> $stable(ptr));

  // R3
  rewind_chk: assert property (@(posedge clk) disable iff (por)
    rst_lvl |=> (ptr == '0));

  // R5
  por_clear_chk: assert property (@(posedge clk)
    por |=> (ptr == '0));

  // R6
  release_at_handoff_chk: assert property (@(posedge clk) disable iff (por)
    !ceo_n |-> !data_en);

  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (por)
    data_en |-> (int'(ptr) <= LAST_ADDR));

  // R8
  stay_spent_chk: assert property (@(posedge clk) disable iff (por)
    (spent && !rst_lvl) |=> spent);

  // R9
  quiet_line_chk: assert property (@(posedge clk) disable iff (por)
    !data_en |-> !data_o);
endmodule

bind serial_cfg_prom serial_cfg_prom_chk #(.LAST_ADDR(LAST_ADDR), .PW(PW)) u_chk (
  .clk    (clk),
  .por    (por),
  .rst_lvl(rst_lvl),
  .ce_n   (ce_n),
  .data_o (data_o),
  .data_en(data_en),
  .ceo_n  (ceo_n),
  .ptr    (ptr),
  .spent  (spent)
);

// File: tb/serial_cfg_prom_test.sv
`timescale 1ns/1ps
module serial_cfg_prom_test;
  import scp_pkg::*;

  localparam int          D0 = 32;
  localparam int          L0 = 19;
  localparam logic [31:0] C0 = 32'hC3A5_96E1;
  localparam int          D1 = 16;
  localparam int          L1 = 15;
  localparam logic [15:0] C1 = 16'h5A3C;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic rst_req = 1'b0;
  logic ld_ce_n = 1'b1;
  logic d0, en0, ceo0_n, d1, en1, ceo1_n;

  int vectors = 0;
  int miscompares = 0;
  string tag = "R5";
  bit collect = 1'b0;
  int rem0[$];
  int rem1[$];
  int stream[$];

  always #2.5 clk = ~clk;

  serial_cfg_prom #(.DEPTH(D0), .LAST_ADDR(L0), .CONTENT(C0),
                    .POLARITY(RST_HIGH_OE_LOW)) uut (
    .clk(clk), .por(por), .rst_oe(rst_req), .ce_n(ld_ce_n),
    .data_o(d0), .data_en(en0), .ceo_n(ceo0_n));

  serial_cfg_prom #(.DEPTH(D1), .LAST_ADDR(L1), .CONTENT(C1),
                    .POLARITY(RST_LOW_OE_HIGH)) uut_next (
    .clk(clk), .por(por), .rst_oe(~rst_req), .ce_n(ceo0_n),
    .data_o(d1), .data_en(en1), .ceo_n(ceo1_n));

  function automatic void refill();
    rem0.delete(); rem1.delete();
    for (int a = 0; a <= L0; a++) rem0.push_back(int'(C0[a]));
    for (int a = 0; a <= L1; a++) rem1.push_back(int'(C1[a]));
  endfunction

  function automatic bit m_ceo0_n();
    return !(rem0.size() == 0 && !ld_ce_n);
  endfunction
  function automatic bit m_en0();
    return !por && !rst_req && !ld_ce_n && rem0.size() > 0;
  endfunction
  function automatic bit m_en1();
    return !por && !rst_req && !m_ceo0_n() && rem1.size() > 0;
  endfunction
  function automatic bit m_ceo1_n();
    return !(rem1.size() == 0 && !m_ceo0_n());
  endfunction

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (por || rst_req) refill();
    else begin
      bit e0, e1;
      e0 = m_en0();
      e1 = m_en1();
      if (e0) void'(rem0.pop_front());
      if (e1) void'(rem1.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!por || $time > 20) begin
      bit e0, e1;
      e0 = m_en0();
      e1 = m_en1();
      check(tag, "dev0 data_en", int'(en0), int'(e0));
      check(tag, "dev0 data_o", int'(d0), e0 ? rem0[0] : 0);
      check(tag, "dev0 ceo_n", int'(ceo0_n), int'(m_ceo0_n()));
      check(tag, "dev1 data_en", int'(en1), int'(e1));
      check(tag, "dev1 data_o", int'(d1), e1 ? rem1[0] : 0);
      check(tag, "dev1 ceo_n", int'(ceo1_n), int'(m_ceo1_n()));
      check("R7", "two drivers", int'(en0 & en1), 0);
      if (collect) begin
        if (en0) stream.push_back(int'(d0));
        else if (en1) stream.push_back(int'(d1));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 5000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    refill();
    step(3);
    #1.5;
    // R5: power-on reset leaves both lines released
    check("R5", "reset en0", int'(en0), 0);
    check("R5", "reset en1", int'(en1), 0);
    check("R5", "reset ceo0_n", int'(ceo0_n), 1);
    @(posedge clk); #1;
    por = 1'b0;
    tag = "R2";
    step(2);
    tag = "R1"; collect = 1'b1; ld_ce_n = 1'b0;
    step(7);
    tag = "R2"; ld_ce_n = 1'b1;
    step(4);
    tag = "R7"; ld_ce_n = 1'b0;
    step(29);
    tag = "R8";
    step(5);
    collect = 1'b0;
    // R7: concatenated stream with no gap or overlap
    check("R7", "stream length", stream.size(), L0 + 1 + L1 + 1);
    for (int a = 0; a < stream.size() && a <= L0 + L1 + 1; a++)
      check("R7", "stream bit", stream[a], a <= L0 ? int'(C0[a]) : int'(C1[a - L0 - 1]));
    #1.5;
    check("R6", "spent ceo0_n", int'(ceo0_n), 0);
    check("R8", "spent en0", int'(en0), 0);
    check("R9", "released data_o", int'(d0), 0);
    @(posedge clk); #1;
    tag = "R6"; ld_ce_n = 1'b1;
    step(2);
    tag = "R4"; rst_req = 1'b1;
    step(2);
    tag = "R3"; rst_req = 1'b0; ld_ce_n = 1'b0;
    step(6);
    tag = "R5"; por = 1'b1;
    step(2);
    por = 1'b0;
    step(4);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule